// File: doc/BRIEF.md
# Display Read-Back Subword Packer

This block sits between the read-data pins of a parallel display panel bus and the write side of a read FIFO. Each strobe from the bus side presents one subword of 8, 16, 18 or 24 bits. The block drops a configured number of leading dummy subwords and does not store them. It then packs the valid subwords into 32-bit words, the earliest in the lowest bits, and offers each word to the FIFO through a valid/ready pair. A transfer ends after a fixed number of valid subwords, set as the product of a line count and a per-line count.

Software sets the configuration inputs and pulses `start`. The block captures the configuration on that pulse and stays busy until the last word has been taken. It then raises `done` for one cycle. When the FIFO holds off, the block keeps its pending word and asserts `bus_stall` toward the bus side so that no subword is dropped. A narrow-data option treats an 8-bit bus as carrying 6 significant bits.

Top module: `rdback_packer`

## Requirements
- R1: A `start` pulse captures all `cfg_*` inputs and clears the dummy, slot and transfer counters. A `start` during a transfer abandons it and begins a fresh one.
- R2: After `start`, the first `cfg_dummy` accepted strobes are discarded, and no part of them reaches `wr_data`.
- R3: Valid subwords are packed little-endian, subword j of a word sitting at bit j*S, where S is the subword width. A word is offered on the cycle after its N-th subword is accepted.
- R4: `cfg_width` selects S: 0 gives 8 (bus bits 7..0), 1 gives 16 (15..0), 2 gives 18 (17..0) and 3 gives 24 (23..0). Bus bits above S are dropped, and every word bit above N*S reads zero.
- R5: The effective N is `cfg_pack`, with 0 taken as 1 and the value limited to 4 for S=8, 2 for S=16 and 1 for S=18 or S=24.
- R6: With `cfg_six_bit` set and S=8, bits 7..6 of every subword read zero. For other widths the flag has no effect.
- R7: Exactly `cfg_lines*cfg_per_line` valid subwords are stored per transfer. Strobes while not busy, or after the final subword, are ignored.
- R8: If the final word is not full, it is offered with its unfilled slots zero.
- R9: `done` is high for exactly one cycle, the cycle after the handshake of the final word. `busy` falls on the same edge.
- R10: If either count is zero at `start`, no word is offered, and `done` pulses on the cycle after `start` while `busy` stays low.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid` and `wr_data` hold and `bus_stall` is high. A strobe held through the stall is taken once the word drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer and capture the configuration |
| cfg_width | input | 2 | Subword width code (0:8, 1:16, 2:18, 3:24) |
| cfg_six_bit | input | 1 | 6 significant bits on an 8-bit bus |
| cfg_dummy | input | 3 | Leading subwords to discard |
| cfg_pack | input | 3 | Requested subwords per output word |
| cfg_lines | input | 16 | Line count |
| cfg_per_line | input | 16 | Subwords per line |
| bus_strobe | input | 1 | Subword present on bus_data |
| bus_data | input | 24 | Subword from the panel bus |
| bus_stall | output | 1 | Bus side must hold its current subword |
| wr_valid | output | 1 | Packed word offered to the FIFO |
| wr_ready | input | 1 | FIFO accepts the word |
| wr_data | output | 32 | Packed word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check four things on every cycle: that a blocked word holds steady, that `done` is a lone pulse seen only with the block idle, that no word appears while idle, and that the zero bits required by the 6-bit and wide-subword formats are present. The bench's scenarios are the only way to show the rest. That covers dummy discard, slot order, N clamping, the exact subword count, partial-word flush, restart and the zero-count case, by comparing every word against values computed from the configuration.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

  typedef enum logic [1:0] {
    SW_8  = 2'd0,
    SW_16 = 2'd1,
    SW_18 = 2'd2,
    SW_24 = 2'd3
  } sw_width_e;

  function automatic logic [4:0] sw_bits(sw_width_e w);
    case (w)
      SW_8:    return 5'd8;
      SW_16:   return 5'd16;
      SW_18:   return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [2:0] sw_max_pack(sw_width_e w);
    case (w)
      SW_8:    return 3'd4;
      SW_16:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/rbp_cfg.sv
module rbp_cfg
  import rbp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DUMMY_W = 3,
  parameter int PACK_W  = 3,
  localparam int XFER_W = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cfg_width,
  input  logic               cfg_six_bit,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic [PACK_W-1:0]  cfg_pack,
  input  logic [CNT_W-1:0]   cfg_lines,
  input  logic [CNT_W-1:0]   cfg_per_line,
  output sw_width_e          width_q,
  output logic               six_q,
  output logic [DUMMY_W-1:0] dummy_q,
  output logic [PACK_W-1:0]  pack_q,
  output logic [XFER_W-1:0]  total_q,
  output logic               zero_total
);

  sw_width_e          width_d;
  logic [PACK_W-1:0]  pack_d;
  logic [PACK_W-1:0]  pack_max;
  logic [XFER_W-1:0]  total_d;

  always_comb begin
    width_d  = sw_width_e'(cfg_width);
    pack_max = PACK_W'(sw_max_pack(width_d));
    pack_d   = cfg_pack;
    if (pack_d == '0)
      pack_d = PACK_W'(1);
    if (pack_d > pack_max)
      pack_d = pack_max;
    total_d    = XFER_W'(cfg_lines) * XFER_W'(cfg_per_line);
    zero_total = (cfg_lines == '0) || (cfg_per_line == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= SW_8;
      six_q   <= 1'b0;
      dummy_q <= '0;
      pack_q  <= PACK_W'(1);
      total_q <= '0;
    end else if (start) begin
      width_q <= width_d;
      six_q   <= cfg_six_bit;
      dummy_q <= cfg_dummy;
      pack_q  <= pack_d;
      total_q <= total_d;
    end
  end

endmodule

// File: rtl/rbp_fmt.sv
module rbp_fmt
  import rbp_pkg::*;
#(
  parameter int BUS_W = 24
) (
  input  sw_width_e          width,
  input  logic               six_bit,
  input  logic [BUS_W-1:0]   raw,
  output logic [BUS_W-1:0]   sub,
  output logic [4:0]         sub_bits
);

  logic             narrow;
  logic [BUS_W-1:0] keep;

  assign sub_bits = sw_bits(width);
  assign narrow   = six_bit && (width == SW_8);

  for (genvar i = 0; i < BUS_W; i++) begin : g_keep
    assign keep[i] = (i < int'(sub_bits)) && !(narrow && (i >= 6));
  end

  assign sub = raw & keep;

endmodule

// File: rtl/rbp_packer.sv
module rbp_packer #(
  parameter int BUS_W   = 24,
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 16,
  parameter int DUMMY_W = 3,
  parameter int PACK_W  = 3,
  localparam int XFER_W = 2 * CNT_W,
  localparam int SH_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               zero_total,
  input  logic               take,
  input  logic [BUS_W-1:0]   sub,
  input  logic [4:0]         sub_bits,
  input  logic [DUMMY_W-1:0] dummy_q,
  input  logic [PACK_W-1:0]  pack_q,
  input  logic [XFER_W-1:0]  total_q,
  input  logic               last_hs,
  output logic               emit,
  output logic [WORD_W-1:0]  emit_data,
  output logic               emit_last,
  output logic               accepting,
  output logic               busy
);

  logic               busy_q, busy_d;
  logic               fed_q, fed_d;
  logic [DUMMY_W-1:0] dcnt_q, dcnt_d;
  logic [PACK_W-1:0]  pos_q, pos_d;
  logic [WORD_W-1:0]  acc_q, acc_d;
  logic [XFER_W-1:0]  xcnt_q, xcnt_d;
  logic               in_dummy;
  logic               final_sub;
  logic               word_full;
  logic [SH_W-1:0]    shamt;
  logic [WORD_W-1:0]  merged;

  assign accepting = busy_q && !fed_q;
  assign busy      = busy_q;
  assign in_dummy  = dcnt_q < dummy_q;
  assign final_sub = (xcnt_q + XFER_W'(1)) == total_q;
  assign word_full = (pos_q + PACK_W'(1)) == pack_q;
  assign shamt     = SH_W'(pos_q) * SH_W'(sub_bits);
  assign merged    = acc_q | (WORD_W'(sub) << shamt);

  always_comb begin
    busy_d    = busy_q;
    fed_d     = fed_q;
    dcnt_d    = dcnt_q;
    pos_d     = pos_q;
    acc_d     = acc_q;
    xcnt_d    = xcnt_q;
    emit      = 1'b0;
    emit_data = merged;
    emit_last = final_sub;
    if (start) begin
      busy_d = !zero_total;
      fed_d  = 1'b0;
      dcnt_d = '0;
      pos_d  = '0;
      acc_d  = '0;
      xcnt_d = '0;
    end else begin
      if (take && accepting) begin
        if (in_dummy) begin
          dcnt_d = dcnt_q + DUMMY_W'(1);
        end else begin
          xcnt_d = xcnt_q + XFER_W'(1);
          if (word_full || final_sub) begin
            emit  = 1'b1;
            acc_d = '0;
            pos_d = '0;
            fed_d = final_sub;
          end else begin
            acc_d = merged;
            pos_d = pos_q + PACK_W'(1);
          end
        end
      end
      if (last_hs)
        busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fed_q  <= 1'b0;
      dcnt_q <= '0;
      pos_q  <= '0;
      acc_q  <= '0;
      xcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      fed_q  <= fed_d;
      dcnt_q <= dcnt_d;
      pos_q  <= pos_d;
      acc_q  <= acc_d;
      xcnt_q <= xcnt_d;
    end
  end

endmodule

// File: rtl/rbp_outreg.sv
module rbp_outreg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              zero_total,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              load_last,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic              stall,
  output logic              last_hs,
  output logic              done
);

  logic              valid_q, valid_d;
  logic              last_q, last_d;
  logic [WORD_W-1:0] data_q;
  logic              done_q, done_d;
  logic              hs;

  assign hs       = valid_q && wr_ready;
  assign last_hs  = hs && last_q;
  assign stall    = valid_q && !wr_ready;
  assign wr_valid = valid_q;
  assign wr_data  = data_q;
  assign done     = done_q;

  always_comb begin
    valid_d = valid_q;
    last_d  = last_q;
    done_d  = 1'b0;
    if (start) begin
      valid_d = 1'b0;
      last_d  = 1'b0;
      done_d  = zero_total;
    end else begin
      done_d = last_hs;
      if (load) begin
        valid_d = 1'b1;
        last_d  = load_last;
      end else if (hs) begin
        valid_d = 1'b0;
        last_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (load && !start)
      data_q <= load_data;
  end

endmodule

// File: rtl/rdback_packer.sv
module rdback_packer
  import rbp_pkg::*;
#(
  parameter int BUS_W   = 24,
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 16,
  parameter int DUMMY_W = 3,
  parameter int PACK_W  = 3,
  localparam int XFER_W = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cfg_width,
  input  logic               cfg_six_bit,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic [PACK_W-1:0]  cfg_pack,
  input  logic [CNT_W-1:0]   cfg_lines,
  input  logic [CNT_W-1:0]   cfg_per_line,
  input  logic               bus_strobe,
  input  logic [BUS_W-1:0]   bus_data,
  output logic               bus_stall,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [WORD_W-1:0]  wr_data,
  output logic               busy,
  output logic               done
);

  sw_width_e          width_q;
  logic               six_q;
  logic [DUMMY_W-1:0] dummy_q;
  logic [PACK_W-1:0]  pack_q;
  logic [XFER_W-1:0]  total_q;
  logic               zero_total;
  logic [BUS_W-1:0]   sub;
  logic [4:0]         sub_bits;
  logic               take;
  logic               emit;
  logic [WORD_W-1:0]  emit_data;
  logic               emit_last;
  logic               accepting;
  logic               last_hs;
  logic               stall;

  assign take      = bus_strobe && !stall;
  assign bus_stall = stall;

  rbp_cfg #(
    .CNT_W(CNT_W), .DUMMY_W(DUMMY_W), .PACK_W(PACK_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_six_bit(cfg_six_bit),
    .cfg_dummy(cfg_dummy), .cfg_pack(cfg_pack),
    .cfg_lines(cfg_lines), .cfg_per_line(cfg_per_line),
    .width_q(width_q), .six_q(six_q), .dummy_q(dummy_q),
    .pack_q(pack_q), .total_q(total_q), .zero_total(zero_total)
  );

  rbp_fmt #(.BUS_W(BUS_W)) u_fmt (
    .width(width_q), .six_bit(six_q), .raw(bus_data),
    .sub(sub), .sub_bits(sub_bits)
  );

  rbp_packer #(
    .BUS_W(BUS_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .DUMMY_W(DUMMY_W), .PACK_W(PACK_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_total(zero_total),
    .take(take), .sub(sub), .sub_bits(sub_bits),
    .dummy_q(dummy_q), .pack_q(pack_q), .total_q(total_q),
    .last_hs(last_hs), .emit(emit), .emit_data(emit_data),
    .emit_last(emit_last), .accepting(accepting), .busy(busy)
  );

  rbp_outreg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_total(zero_total),
    .load(emit), .load_data(emit_data), .load_last(emit_last),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
    .stall(stall), .last_hs(last_hs), .done(done)
  );

endmodule

// File: rtl/rdback_packer_chk.sv
module rdback_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  cfg_width,
  input logic        cfg_six_bit,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done,
  input logic        bus_stall
);

  logic [1:0] w_seen;
  logic       six_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_seen   <= 2'd0;
      six_seen <= 1'b0;
    end else if (start) begin
      w_seen   <= cfg_width;
      six_seen <= cfg_six_bit;
    end
  end

  AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !start) |=> (wr_valid && $stable(wr_data))); // R11
  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> busy); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_valid)); // R9
  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(wr_valid)); // R7
  AST_SIX_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && six_seen && w_seen == 2'd0) |-> ((wr_data & 32'hC0C0_C0C0) == 32'd0)); // R6
  AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && w_seen[1]) |-> (wr_data[31:24] == 8'd0)); // R4

endmodule

bind rdback_packer rdback_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
  .cfg_six_bit(cfg_six_bit), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .busy(busy), .done(done), .bus_stall(bus_stall)
);

// File: tb/rdback_packer_test.sv
module rdback_packer_test;

  typedef struct packed {
    logic [1:0] w;
    logic       six;
    logic [2:0] dum;
    logic [2:0] pk;
    logic [7:0] ln;
    logic [7:0] pl;
    logic [7:0] seed;
    logic       bp;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 1'b0, 3'd1, 3'd4, 8'd2, 8'd4, 8'h11, 1'b0},
    '{2'd0, 1'b0, 3'd0, 3'd3, 8'd3, 8'd2, 8'h22, 1'b1},
    '{2'd1, 1'b0, 3'd2, 3'd2, 8'd1, 8'd5, 8'h33, 1'b0},
    '{2'd2, 1'b0, 3'd1, 3'd1, 8'd2, 8'd2, 8'h44, 1'b1},
    '{2'd3, 1'b0, 3'd0, 3'd2, 8'd1, 8'd3, 8'h55, 1'b0},
    '{2'd0, 1'b1, 3'd3, 3'd4, 8'd1, 8'd7, 8'h66, 1'b1},
    '{2'd0, 1'b0, 3'd0, 3'd7, 8'd1, 8'd4, 8'h77, 1'b0},
    '{2'd1, 1'b0, 3'd0, 3'd0, 8'd2, 8'd1, 8'h88, 1'b0},
    '{2'd1, 1'b1, 3'd1, 3'd2, 8'd1, 8'd2, 8'h99, 1'b1}
  };

  logic        clk, rst_n, start;
  logic [1:0]  cfg_width;
  logic        cfg_six_bit;
  logic [2:0]  cfg_dummy, cfg_pack;
  logic [15:0] cfg_lines, cfg_per_line;
  logic        bus_strobe;
  logic [23:0] bus_data;
  logic        bus_stall, wr_valid, wr_ready, busy, done;
  logic [31:0] wr_data;

  int n_chk, n_bad;
  logic [31:0] exp_w [16];
  int exp_n, rx_idx, done_cnt;
  int bp_mode;
  logic man_ready;
  string cur_req;
  bit finished;

  rdback_packer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
    .cfg_six_bit(cfg_six_bit), .cfg_dummy(cfg_dummy), .cfg_pack(cfg_pack),
    .cfg_lines(cfg_lines), .cfg_per_line(cfg_per_line),
    .bus_strobe(bus_strobe), .bus_data(bus_data), .bus_stall(bus_stall),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // FIFO side: choose ready, then compare the word that the next edge takes
  always @(negedge clk) begin
    if (bp_mode == 0)      wr_ready = 1'b1;
    else if (bp_mode == 1) wr_ready = ~wr_ready;
    else                   wr_ready = man_ready;
    if (rst_n && wr_valid && wr_ready) begin
      if (rx_idx < exp_n)
        check({cur_req, " R3 word"}, wr_data, exp_w[rx_idx]);
      else
        check({cur_req, " R7 extra word"}, wr_data, 32'hDEAD_BEEF);
      rx_idx++;
    end
    if (rst_n && done) done_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    wrap_up();
  end

  task automatic settle();
    @(negedge clk); #2;
  endtask

  function automatic logic [23:0] raw_sw(input logic [7:0] seed, input int k);
    logic [7:0] k8 = 8'(k);
    return {seed ^ k8, k8 * 8'd37 + 8'd5, seed + k8};
  endfunction

  task automatic feed(input logic [23:0] d);
    @(negedge clk);
    bus_strobe = 1'b1;
    bus_data   = d;
    #1;
    while (bus_stall) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_start(input row_t r);
    @(negedge clk);
    cfg_width = r.w; cfg_six_bit = r.six; cfg_dummy = r.dum; cfg_pack = r.pk;
    cfg_lines = 16'(r.ln); cfg_per_line = 16'(r.pl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_row(input row_t r, input string req);
    int n, bits, total, pos;
    logic [31:0] acc, m;
    bits  = (r.w == 2'd0) ? 8 : (r.w == 2'd1) ? 16 : (r.w == 2'd2) ? 18 : 24;
    m     = (32'd1 << bits) - 32'd1;
    if (r.w == 2'd0 && r.six) m = 32'h3F;
    n     = (r.pk == 0) ? 1 : int'(r.pk);
    if (n > 32 / bits) n = (bits == 8) ? 4 : (bits == 16) ? 2 : 1;
    total = int'(r.ln) * int'(r.pl);
    exp_n = 0; acc = 0; pos = 0;
    for (int k = 0; k < total; k++) begin
      acc = acc | ((32'(raw_sw(r.seed, k)) & m) << (pos * bits));
      pos++;
      if (pos == n || k == total - 1) begin
        exp_w[exp_n] = acc; exp_n++; acc = 0; pos = 0;
      end
    end
    cur_req  = req;
    rx_idx   = 0;
    done_cnt = 0;
    bp_mode  = r.bp ? 1 : 0;
    pulse_start(r);
    for (int k = 0; k < int'(r.dum); k++) feed(24'hFF_FFFF); // R2 dummies never stored
    for (int k = 0; k < total; k++) feed(raw_sw(r.seed, k));
    @(negedge clk);
    bus_strobe = 1'b0;
    for (int t = 0; t < 40 && done_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    check({req, " R7 word count"}, 32'(rx_idx), 32'(exp_n));
    check({req, " R9 done pulses"}, 32'(done_cnt), 32'd1);
    check({req, " R9 busy low"}, 32'(busy), 32'd0);
    bp_mode = 0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    exp_n = 0; rx_idx = 0; done_cnt = 0; bp_mode = 0; man_ready = 1'b0;
    cur_req = "";
    rst_n = 1'b0; start = 1'b0; bus_strobe = 1'b0; bus_data = '0;
    cfg_width = '0; cfg_six_bit = 1'b0; cfg_dummy = '0; cfg_pack = '0;
    cfg_lines = '0; cfg_per_line = '0; wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 reset valid", 32'(wr_valid), 32'd0);
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset stall", 32'(bus_stall), 32'd0);

    // R7: strobes before any start are ignored
    exp_n = 0; rx_idx = 0;
    @(negedge clk); bus_strobe = 1'b1; bus_data = 24'h123456;
    repeat (3) @(negedge clk);
    bus_strobe = 1'b0;
    settle();
    check("R7 idle strobes", {30'd0, wr_valid, busy}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NROWS; i++) begin
      string tag;
      case (i)
        0: tag = "R2 R3 8-bit N4";
        1: tag = "R3 8-bit N3 rgb";
        2: tag = "R8 R2 16-bit partial";
        3: tag = "R4 18-bit";
        4: tag = "R5 R4 24-bit clamp";
        5: tag = "R6 R8 six-bit partial";
        6: tag = "R5 8-bit clamp";
        7: tag = "R5 zero N";
        default: tag = "R6 six ignored 16-bit";
      endcase
      run_row(ROWS[i], tag);
    end

    // R7: strobes after the final subword are ignored
    @(negedge clk); bus_strobe = 1'b1; bus_data = 24'hABCDEF;
    repeat (2) @(negedge clk);
    bus_strobe = 1'b0;
    settle();
    check("R7 strobe after done", {30'd0, wr_valid, busy}, 32'd0);

    // R10: zero count
    done_cnt = 0; rx_idx = 0; exp_n = 0;
    pulse_start('{2'd0, 1'b0, 3'd0, 3'd1, 8'd0, 8'd5, 8'h00, 1'b0});
    #2;
    check("R10 done after start", 32'(done), 32'd1);
    check("R10 busy low", 32'(busy), 32'd0);
    settle();
    check("R10 done single", 32'(done), 32'd0);
    check("R10 no word", 32'(rx_idx), 32'd0);

    // R1: abandon a transfer part way, then a fresh run must start clean
    pulse_start('{2'd0, 1'b0, 3'd2, 3'd4, 8'd1, 8'd4, 8'h10, 1'b0});
    feed(24'hFF_FFFF); feed(24'hFF_FFFF); feed(24'h0000AA);
    @(negedge clk); bus_strobe = 1'b0;
    run_row('{2'd0, 1'b0, 3'd2, 3'd4, 8'd1, 8'd4, 8'h10, 1'b0}, "R1 restart");

    // R11: backpressure holds the word and stalls the bus
    exp_w[0] = 32'h0000_00A5; exp_w[1] = 32'h0000_003C; exp_n = 2;
    rx_idx = 0; done_cnt = 0; cur_req = "R11 backpressure";
    man_ready = 1'b0; bp_mode = 2;
    pulse_start('{2'd0, 1'b0, 3'd0, 3'd1, 8'd1, 8'd2, 8'h00, 1'b0});
    bus_strobe = 1'b1; bus_data = 24'h1234A5;
    @(negedge clk);
    bus_data = 24'h56783C;
    #2;
    check("R11 valid while blocked", 32'(wr_valid), 32'd1);
    check("R11 stall raised", 32'(bus_stall), 32'd1);
    repeat (3) settle();
    check("R11 data held", wr_data, 32'h0000_00A5);
    check("R11 still stalled", 32'(bus_stall), 32'd1);
    man_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_strobe = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    check("R11 words drained", 32'(rx_idx), 32'd2);
    check("R11 R9 done once", 32'(done_cnt), 32'd1);
    bp_mode = 0;

    repeat (3) @(negedge clk);
    wrap_up();
  end

endmodule